// File: doc/BRIEF.md
# Calibrated Seconds Divider with Test Output

This block turns a stream of oscillator ticks (one enable pulse per cycle of a 32.768 kHz crystal, synchronised into the system clock domain) into a one-cycle seconds pulse for a calendar counter. It also makes a fixed 512 Hz square wave and a 1 Hz square wave. A digital rate trim corrects the timebase. It does not pull the crystal. Instead it changes the length of one seconds period at regular intervals. When the trim slows the clock, one second in every slow window is made longer. When the trim speeds the clock, one second in every fast window is made shorter. The 1 Hz square wave follows the trimmed periods. The 512 Hz wave ignores the trim.

A single output pin shows one of three things: a static level chosen by software, the untrimmed 512 Hz tone, or the trimmed 1 Hz wave. In a lab, the 1 Hz selection lets the trim be measured. A stop input freezes every counter and holds the seconds pulse low. With the default parameters the slow window is 8 minutes with a stretch of 32·N ticks, which gives about +2 ppm per step. The fast window is 16 minutes with a cut of 128·N ticks, which gives about −4 ppm per step.

Top module: `cal_tick_gen`

## Requirements
- R1: While reset is low and on the first cycle after it, `sec_pulse` is 0 and `pin_out` is 1; the divider count, the tone phase and both window counters restart from zero.
- R2: With no trim in effect, `sec_pulse` rises for exactly one clock cycle on the clock edge that takes in every DIV_CYCLES-th accepted oscillator tick.
- R3: With `cal_speed`=0 and magnitude N, the second whose index since reset is k·SLOW_WIN−1 (k ≥ 1) lasts DIV_CYCLES + SLOW_STEP·N ticks, and every other second lasts DIV_CYCLES ticks.
- R4: With `cal_speed`=1 and magnitude N, the second whose index since reset is k·FAST_WIN−1 lasts DIV_CYCLES − FAST_STEP·N ticks, and every other second, including the slow-window seconds, lasts DIV_CYCLES ticks.
- R5: A magnitude of 0 leaves every second at DIV_CYCLES ticks for either sign.
- R6: While `stop` is 1, ticks are not counted and `sec_pulse` stays 0. When `stop` is released, counting resumes from the count that was held. A tick that would have ended a second while stopped does not end it.
- R7: With `test_en`=0, `pin_out` equals `out_level` one clock later.
- R8: With `test_en`=1 and `test_1hz`=0, `pin_out` is a square wave that starts low after reset and toggles every TEST_HALF accepted ticks, whatever the trim is.
- R9: With `test_en`=1 and `test_1hz`=1, `pin_out` is high for the first DIV_CYCLES/2 ticks of each second and low for the rest, so a stretch or cut changes only the low phase.
- R10: The window counters restart with reset, so the first trimmed second after a reset is second index SLOW_WIN−1 (slowing) or FAST_WIN−1 (speeding).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| osc_tick | input | 1 | One-cycle pulse per oscillator cycle |
| stop | input | 1 | Freezes all counters and holds the seconds pulse low |
| cal_mag | input | 5 | Trim magnitude N (0 to 31) |
| cal_speed | input | 1 | 0 lengthens periods (slows), 1 shortens them (speeds) |
| test_en | input | 1 | 0 selects the static level on the pin, 1 selects a test wave |
| test_1hz | input | 1 | With test_en=1: 0 selects the 512 Hz tone, 1 selects the trimmed 1 Hz wave |
| out_level | input | 1 | Static pin level used when test_en=0 |
| sec_pulse | output | 1 | One-cycle pulse at the end of each second |
| pin_out | output | 1 | Registered output pin level |

## Verification
Two events can fall on the same clock edge. The tick that ends a second also advances the window counters, and on that same edge the limit for the next second switches between trimmed and untrimmed. The bench runs through many window boundaries with the largest magnitude of each sign, and also with random magnitudes, signs and pin modes. Every measured period is compared with a model that numbers the seconds since reset. The second coincidence is a stop request arriving on exactly the tick that would end a second. The bench steers the model count to one tick before the end of a second, raises `stop`, and then expects no pulse while stopped and a pulse on the first tick after release.

// File: rtl/cal_tick_pkg.sv
// Shared types for the calibrated seconds divider.
// Assumes: nothing beyond the standard language.
package cal_tick_pkg;

    // Source shown on the output pin.
    typedef enum logic [1:0] {
        SRC_LEVEL   = 2'd0,
        SRC_TONE    = 2'd1,
        SRC_SECWAVE = 2'd2
    } pin_src_e;

    // Decode the two control bits into a pin source.
    function automatic pin_src_e select_src(input logic test_en, input logic test_1hz);
        if (!test_en)
            return SRC_LEVEL;
        else if (test_1hz)
            return SRC_SECWAVE;
        else
            return SRC_TONE;
    endfunction

endpackage

// File: rtl/sec_window.sv
// Counts seconds modulo WIN and flags the last second of each window.
// Assumes: sec_tick is a one-cycle pulse; WIN >= 2.
module sec_window #(
    parameter int WIN = 480
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sec_tick,
    output logic due
);
    localparam int IW = (WIN > 1) ? $clog2(WIN) : 1;
    localparam logic [IW-1:0] LAST = IW'(WIN - 1);

    logic [IW-1:0] idx;

    // Advance the second index on each seconds pulse, wrapping at the window end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx <= '0;
        else if (sec_tick)
            idx <= (idx == LAST) ? '0 : idx + 1'b1;
    end

    assign due = (idx == LAST);

    assert_window_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_tick |=> $stable(idx));
    assert_window_enter_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(due) |-> $past(sec_tick));
endmodule

// File: rtl/sec_divider.sv
// Divides accepted oscillator ticks by a per-second limit. It issues a one-cycle
// seconds pulse and a registered 1 Hz wave that is high for the first HALF ticks.
// Assumes: limit > HALF and limit <= LONGEST; limit may change at any time
// (a count already past a new, shorter limit ends the second on the next tick).
module sec_divider #(
    parameter int HALF    = 16384,
    parameter int LONGEST = 33760,
    parameter int CNT_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_tick,
    input  logic             stop,
    input  logic [CNT_W-1:0] limit,
    output logic             sec_tick,
    output logic             wave
);
    localparam logic [CNT_W:0] HALF_L = (CNT_W+1)'(HALF);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt} + 1'b1;

    // Count accepted ticks, end the second at the limit and shape the 1 Hz wave.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            sec_tick <= 1'b0;
            wave     <= 1'b1;
        end else begin
            sec_tick <= 1'b0;
            if (osc_tick && !stop) begin
                if (cnt_inc >= {1'b0, limit}) begin
                    cnt      <= '0;
                    sec_tick <= 1'b1;
                    wave     <= 1'b1;
                end else begin
                    cnt  <= cnt_inc[CNT_W-1:0];
                    wave <= (cnt_inc < HALF_L);
                end
            end
        end
    end

    assert_pulse_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> !sec_tick);
    assert_stop_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !sec_tick);
    assert_stop_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> $stable(cnt));
    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CNT_W'(LONGEST));
endmodule

// File: rtl/tone_gen.sv
// Untrimmed test tone: toggles every HALF accepted oscillator ticks.
// Assumes: HALF >= 2; the tone never sees the rate trim.
module tone_gen #(
    parameter int HALF = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_tick,
    input  logic stop,
    output logic wave
);
    localparam int TW = $clog2(HALF);
    localparam logic [TW-1:0] LAST = TW'(HALF - 1);

    logic [TW-1:0] cnt;

    // Count ticks in a half period and flip the tone at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            wave <= 1'b0;
        end else if (osc_tick && !stop) begin
            if (cnt == LAST) begin
                cnt  <= '0;
                wave <= ~wave;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assert_tone_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(osc_tick && !stop) |=> $stable(wave));
endmodule

// File: rtl/pin_select.sv
// Registers the chosen source onto the output pin.
// Assumes: both waves are registered; the pin lags its source by one clock.
module pin_select
    import cal_tick_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  pin_src_e src,
    input  logic     level,
    input  logic     tone,
    input  logic     secwave,
    output logic     pin
);
    // Pick the pin source; the pin idles high in reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pin <= 1'b1;
        else begin
            case (src)
                SRC_TONE:    pin <= tone;
                SRC_SECWAVE: pin <= secwave;
                default:     pin <= level;
            endcase
        end
    end

    assert_level_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_LEVEL) |=> (pin == $past(level)));
    assert_secwave_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_SECWAVE) |=> (pin == $past(secwave)));
endmodule

// File: rtl/cal_tick_gen.sv
// Calibrated seconds divider with test output (top).
// Builds the per-second limit from the trim inputs and the two window flags.
// Slowing stretches the last second of each slow window; speeding shortens the
// last second of each fast window.
// Assumes: osc_tick is already synchronous to clk; FAST_STEP*31 < DIV_CYCLES/2.
module cal_tick_gen
    import cal_tick_pkg::*;
#(
    parameter int DIV_CYCLES = 32768,
    parameter int TEST_HALF  = 32,
    parameter int SLOW_STEP  = 32,
    parameter int FAST_STEP  = 128,
    parameter int SLOW_WIN   = 480,
    parameter int FAST_WIN   = 960,
    parameter int MAG_W      = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_tick,
    input  logic             stop,
    input  logic [MAG_W-1:0] cal_mag,
    input  logic             cal_speed,
    input  logic             test_en,
    input  logic             test_1hz,
    input  logic             out_level,
    output logic             sec_pulse,
    output logic             pin_out
);
    localparam int MAG_MAX  = (1 << MAG_W) - 1;
    localparam int LONGEST  = DIV_CYCLES + SLOW_STEP * MAG_MAX;
    localparam int CNT_W    = $clog2(LONGEST + 1);
    localparam int HALF_SEC = DIV_CYCLES / 2;
    localparam int NWIN     = 2;
    localparam int WINS [NWIN] = '{SLOW_WIN, FAST_WIN};
    localparam logic [CNT_W-1:0] BASE = CNT_W'(DIV_CYCLES);

    logic [NWIN-1:0]  due;
    logic [CNT_W-1:0] mag_w;
    logic [CNT_W-1:0] stretch;
    logic [CNT_W-1:0] shrink;
    logic [CNT_W-1:0] limit;
    logic             wave_sec;
    logic             wave_tone;
    pin_src_e         src;

    // One window counter per trim direction (index 0 slow, index 1 fast).
    for (genvar g = 0; g < NWIN; g++) begin : g_win
        sec_window #(.WIN(WINS[g])) u_win (
            .clk      (clk),
            .rst_n    (rst_n),
            .sec_tick (sec_pulse),
            .due      (due[g])
        );
    end

    // Length of the current second from the base, the sign and the window flags.
    always_comb begin
        mag_w   = CNT_W'(cal_mag);
        stretch = (due[0] && !cal_speed) ? CNT_W'(SLOW_STEP) * mag_w : '0;
        shrink  = (due[1] &&  cal_speed) ? CNT_W'(FAST_STEP) * mag_w : '0;
        limit   = BASE + stretch - shrink;
    end

    sec_divider #(.HALF(HALF_SEC), .LONGEST(LONGEST), .CNT_W(CNT_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_tick (osc_tick),
        .stop     (stop),
        .limit    (limit),
        .sec_tick (sec_pulse),
        .wave     (wave_sec)
    );

    tone_gen #(.HALF(TEST_HALF)) u_tone (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_tick (osc_tick),
        .stop     (stop),
        .wave     (wave_tone)
    );

    assign src = select_src(test_en, test_1hz);

    pin_select u_pin (
        .clk     (clk),
        .rst_n   (rst_n),
        .src     (src),
        .level   (out_level),
        .tone    (wave_tone),
        .secwave (wave_sec),
        .pin     (pin_out)
    );
endmodule

// File: tb/cal_tick_gen_tb.sv
module cal_tick_gen_tb;
    localparam int DIV = 256;
    localparam int TH  = 4;
    localparam int SS  = 2;
    localparam int FS  = 4;
    localparam int SW  = 4;
    localparam int FW  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic osc_tick = 1'b0;
    logic stop = 1'b0;
    logic [4:0] cal_mag = '0;
    logic cal_speed = 1'b0;
    logic test_en = 1'b0;
    logic test_1hz = 1'b0;
    logic out_level = 1'b1;
    logic sec_pulse;
    logic pin_out;

    int n_chk = 0;
    int n_fail = 0;
    int m_cnt = 0;
    int m_idx = 0;
    int m_total = 0;

    always #5 clk = ~clk;

    cal_tick_gen #(
        .DIV_CYCLES(DIV), .TEST_HALF(TH), .SLOW_STEP(SS), .FAST_STEP(FS),
        .SLOW_WIN(SW), .FAST_WIN(FW), .MAG_W(5)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .stop(stop),
        .cal_mag(cal_mag), .cal_speed(cal_speed), .test_en(test_en),
        .test_1hz(test_1hz), .out_level(out_level),
        .sec_pulse(sec_pulse), .pin_out(pin_out)
    );

    // Expected length of second number idx (R3, R4, R5).
    function automatic int exp_len(input int idx);
        int len = DIV;
        if (!cal_speed && (idx % SW) == SW - 1) len += SS * int'(cal_mag);
        if ( cal_speed && (idx % FW) == FW - 1) len -= FS * int'(cal_mag);
        return len;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // Pin expectation from the current controls and the model waves (R7, R8, R9).
    task automatic chk_pin();
        int e;
        string tag;
        if (!test_en) begin e = int'(out_level); tag = "R7"; end
        else if (test_1hz) begin e = (m_cnt < DIV/2) ? 1 : 0; tag = "R9"; end
        else begin e = (m_total / TH) % 2; tag = "R8"; end
        check(int'(pin_out) == e, tag, int'(pin_out), e);
    endtask

    // One oscillator tick; pulse checked in the cycle after the consuming edge.
    task automatic step(input string tag);
        int ep = 0;
        @(negedge clk);
        chk_pin();
        osc_tick = 1'b1;
        @(negedge clk);
        osc_tick = 1'b0;
        if (!stop) begin
            m_cnt++;
            m_total++;
            if (m_cnt >= exp_len(m_idx)) begin
                ep = 1;
                m_cnt = 0;
                m_idx++;
            end
        end
        check(int'(sec_pulse) == ep, stop ? "R6" : tag, int'(sec_pulse), ep);
    endtask

    task automatic run_secs(input int n, input string tag);
        for (int i = 0; i < n * DIV; i++) step(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        osc_tick = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(sec_pulse == 1'b0, "R1", int'(sec_pulse), 0);
        check(pin_out == 1'b1, "R1", int'(pin_out), 1);
        rst_n = 1'b1;
        m_cnt = 0;
        m_idx = 0;
        m_total = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got 0 expected 1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        do_reset();

        // R2/R7: untrimmed seconds, pin follows a random level.
        for (int i = 0; i < 2 * DIV; i++) begin
            out_level = 1'($urandom);
            step("R2");
        end

        // R3/R9: largest slow trim, 1 Hz wave on the pin.
        do_reset();
        cal_mag = 5'd31; cal_speed = 1'b0; test_en = 1'b1; test_1hz = 1'b1;
        run_secs(2 * SW + 1, "R3");

        // R4/R8: largest fast trim, tone on the pin stays untrimmed.
        do_reset();
        cal_speed = 1'b1; test_1hz = 1'b0;
        run_secs(FW + 2, "R4");

        // R5: zero magnitude, both signs.
        cal_mag = 5'd0; test_1hz = 1'b1;
        run_secs(FW, "R5");
        cal_speed = 1'b0;
        run_secs(SW, "R5");

        // R10: reset in mid-window restarts the window count.
        cal_mag = 5'd20; cal_speed = 1'b1;
        for (int i = 0; i < 3 * DIV / 2; i++) step("R4");
        do_reset();
        cal_speed = 1'b0; cal_mag = 5'd31;
        run_secs(SW + 1, "R10");

        // Random trims and pin modes, with changes landing mid-second.
        for (int r = 0; r < 6; r++) begin
            int n = 300 + int'($urandom % 900);
            cal_mag   = 5'($urandom);
            cal_speed = 1'($urandom);
            test_en   = 1'($urandom);
            test_1hz  = 1'($urandom);
            out_level = 1'($urandom);
            for (int i = 0; i < n; i++) step(cal_speed ? "R4" : "R3");
        end

        // R6: stop arrives exactly on the tick that would end a second.
        cal_mag = 5'd0; test_en = 1'b1; test_1hz = 1'b0;
        while (m_cnt != exp_len(m_idx) - 1) step("R2");
        stop = 1'b1;
        for (int i = 0; i < 100; i++) step("R6");
        stop = 1'b0;
        step("R6");
        check(m_cnt == 0, "R6", m_cnt, 0);
        test_1hz = 1'b1;
        run_secs(1, "R6");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule